// File: doc/BRIEF.md
# Sink Power-Offer Selection Engine

This block decides which fixed-voltage power offer a USB-PD power sink accepts. Four configuration levels arrive as ADC readings in millivolts. Two set the lowest and highest voltage the sink will take. The other two set a coarse and a fine current step. The coarse and fine steps add up to the operating current the sink asks for. Separately, the source's list of offers is latched on a strobe. Each entry carries a valid bit, a voltage and a maximum current.

One cycle after a strobe, the engine publishes three results: the index of the accepted entry, the operating current to request, and a safe-power flag. The flag is raised when no entry is acceptable; the sink then falls back to a 5 V / 900 mA supply instead of a contract. A host may write its own voltage window and current, and these replace the pin-derived limits until the next reset. Between updates the outputs stay frozen.

Top module: `sink_offer_select`

## Requirements
- R1: Among qualifying offers, the one with the highest voltage is selected.
- R2: An offer qualifies only if its voltage lies inside the window, with both ends inclusive. The low end is the minimum voltage limit and the high end is the maximum voltage limit. An empty window (minimum above maximum) qualifies nothing.
- R3: The coarse current level decodes by millivolt band. 0–248 gives 0, 249–786 gives 100, 787–1347 gives 200, 1348–1920 gives 300, 1921–2778 gives 400, and 2779 or more gives 500. All currents are in 10 mA units.
- R4: The fine current level decodes by millivolt band. 0–248 gives 0, 249–786 gives 25, 787–1347 gives 50, 1348–1920 gives 75, and 1921 or more gives 90 (10 mA units).
- R5: The requested current equals the coarse step plus the fine step. An offer qualifies only if its maximum current is at least this value. When a contract is made, `op_cur` reports the requested current.
- R6: Entries whose valid bit is clear never qualify. Among qualifying offers of equal voltage, the lowest index wins.
- R7: The minimum-voltage and maximum-voltage levels each decode by millivolt band. 0–786 gives 100, 787–1347 gives 180, 1348–1920 gives 300, and 1921 or more gives 400. These are in 50 mV units, i.e. 5, 9, 15 and 20 V.
- R8: A host write replaces all three limits: minimum voltage, maximum voltage and current. The host limits stay in force across later list strobes until reset. After reset, the pin-derived limits apply again.
- R9: When no offer qualifies, the outputs fall back to safe power: `safe_pwr` is 1, `pick_idx` is 0 and `op_cur` is 90 (900 mA).
- R10: Reset sets the outputs to the safe-power values. A strobe or host write sampled at one rising edge updates the outputs at the next rising edge. Otherwise the outputs hold, even when pin levels or list inputs change. Entry i of the list occupies bits [i*10 +: 10] of both `list_volt` and `list_imax`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_vmin_mv | input | 12 | Minimum-voltage level, mV |
| pin_vmax_mv | input | 12 | Maximum-voltage level, mV |
| pin_crs_mv | input | 12 | Coarse current level, mV |
| pin_fin_mv | input | 12 | Fine current level, mV |
| list_stb | input | 1 | Latch a new offer list |
| list_valid | input | 7 | Valid bit per entry |
| list_volt | input | 70 | Entry voltages, 50 mV units |
| list_imax | input | 70 | Entry maximum currents, 10 mA units |
| host_wr | input | 1 | Write host limits |
| host_vmin | input | 10 | Host minimum voltage, 50 mV units |
| host_vmax | input | 10 | Host maximum voltage, 50 mV units |
| host_isnk | input | 10 | Host operating current, 10 mA units |
| pick_idx | output | 3 | Index of accepted entry |
| op_cur | output | 10 | Requested operating current, 10 mA units |
| safe_pwr | output | 1 | No acceptable offer; safe power in use |

## Verification
A list strobe and a host write can land in the same cycle. In that case, the selection must use both the newly latched list and the newly written limits. The bench drives both strobes on one edge with a list and a window for which the old and new inputs lead to different indices and currents. It then compares the single update that follows against the result expected from the new pair only.

// File: rtl/sps_pkg.sv
package sps_pkg;

    localparam int MV_W   = 12;
    localparam int VOLT_W = 10;
    localparam int CUR_W  = 10;

    typedef logic [MV_W-1:0]   mv_t;
    typedef logic [VOLT_W-1:0] volt_t;
    typedef logic [CUR_W-1:0]  cur_t;

    // divider band edges (lower bound of each band, mV)
    localparam mv_t EDGE_1 = mv_t'(249);
    localparam mv_t EDGE_2 = mv_t'(787);
    localparam mv_t EDGE_3 = mv_t'(1348);
    localparam mv_t EDGE_4 = mv_t'(1921);
    localparam mv_t EDGE_5 = mv_t'(2779);

    localparam cur_t SAFE_CUR  = cur_t'(90);
    localparam cur_t FINE_CAP  = cur_t'(90);
    localparam cur_t CRS_CAP   = cur_t'(500);

    typedef struct packed {
        volt_t vmin;
        volt_t vmax;
        cur_t  isnk;
    } limits_t;

    typedef struct packed {
        logic  valid;
        volt_t volt;
        cur_t  imax;
    } offer_t;

    function automatic cur_t coarse_step(input mv_t mv);
        if (mv >= EDGE_5)      return cur_t'(500);
        else if (mv >= EDGE_4) return cur_t'(400);
        else if (mv >= EDGE_3) return cur_t'(300);
        else if (mv >= EDGE_2) return cur_t'(200);
        else if (mv >= EDGE_1) return cur_t'(100);
        else                   return cur_t'(0);
    endfunction

    function automatic cur_t fine_step(input mv_t mv);
        if (mv >= EDGE_4)      return cur_t'(90);
        else if (mv >= EDGE_3) return cur_t'(75);
        else if (mv >= EDGE_2) return cur_t'(50);
        else if (mv >= EDGE_1) return cur_t'(25);
        else                   return cur_t'(0);
    endfunction

    function automatic volt_t volt_level(input mv_t mv);
        if (mv >= EDGE_4)      return volt_t'(400);
        else if (mv >= EDGE_3) return volt_t'(300);
        else if (mv >= EDGE_2) return volt_t'(180);
        else                   return volt_t'(100);
    endfunction

endpackage

// File: rtl/sps_pin_decode.sv
module sps_pin_decode
    import sps_pkg::*;
(
    input  mv_t     vmin_mv,
    input  mv_t     vmax_mv,
    input  mv_t     crs_mv,
    input  mv_t     fin_mv,
    output limits_t lim
);

    cur_t crs_i;
    cur_t fin_i;

    always_comb begin
        crs_i    = coarse_step(crs_mv);
        fin_i    = fine_step(fin_mv);
        lim.vmin = volt_level(vmin_mv);
        lim.vmax = volt_level(vmax_mv);
        lim.isnk = crs_i + fin_i;
        assert_coarse_cap_R3: assert (crs_i <= CRS_CAP);
        assert_fine_cap_R4:   assert (fin_i <= FINE_CAP);
    end

endmodule

// File: rtl/sps_offer_pick.sv
module sps_offer_pick
    import sps_pkg::*;
#(
    parameter int N_OFFERS = 7,
    parameter int IDX_W    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  offer_t           offers [N_OFFERS],
    input  limits_t          lim,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    logic [N_OFFERS-1:0] qual;
    volt_t               best_v;

    for (genvar g = 0; g < N_OFFERS; g++) begin : g_qual
        assign qual[g] = offers[g].valid
                       && (offers[g].volt >= lim.vmin)
                       && (offers[g].volt <= lim.vmax)
                       && (offers[g].imax >= lim.isnk);
    end

    // strict compare keeps the earliest entry on equal voltage
    always_comb begin
        found  = 1'b0;
        idx    = '0;
        best_v = '0;
        for (int i = 0; i < N_OFFERS; i++) begin
            if (qual[i] && (!found || offers[i].volt > best_v)) begin
                found  = 1'b1;
                idx    = IDX_W'(i);
                best_v = offers[i].volt;
            end
        end
    end

    always @(posedge clk) begin
        if (!rst && found) begin
            assert_pick_window_R2: assert (offers[idx].valid
                && offers[idx].volt >= lim.vmin && offers[idx].volt <= lim.vmax);
            assert_pick_current_R5: assert (offers[idx].imax >= lim.isnk);
            for (int j = 0; j < N_OFFERS; j++) begin
                if (qual[j]) begin
                    assert_pick_best_R1: assert (offers[j].volt < offers[idx].volt
                        || (offers[j].volt == offers[idx].volt && j >= int'(idx)));
                end
            end
        end
        if (!rst && !found) begin
            assert_pick_none_R9: assert (qual == '0);
        end
    end

endmodule

// File: rtl/sink_offer_select.sv
module sink_offer_select
    import sps_pkg::*;
#(
    parameter int N_OFFERS = 7,
    localparam int IDX_W   = (N_OFFERS > 1) ? $clog2(N_OFFERS) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [MV_W-1:0]            pin_vmin_mv,
    input  logic [MV_W-1:0]            pin_vmax_mv,
    input  logic [MV_W-1:0]            pin_crs_mv,
    input  logic [MV_W-1:0]            pin_fin_mv,
    input  logic                       list_stb,
    input  logic [N_OFFERS-1:0]        list_valid,
    input  logic [N_OFFERS*VOLT_W-1:0] list_volt,
    input  logic [N_OFFERS*CUR_W-1:0]  list_imax,
    input  logic                       host_wr,
    input  logic [VOLT_W-1:0]          host_vmin,
    input  logic [VOLT_W-1:0]          host_vmax,
    input  logic [CUR_W-1:0]           host_isnk,
    output logic [IDX_W-1:0]           pick_idx,
    output logic [CUR_W-1:0]           op_cur,
    output logic                       safe_pwr
);

    offer_t           tbl [N_OFFERS];
    limits_t          pin_lim;
    limits_t          host_lim;
    limits_t          act_lim;
    logic             host_act;
    logic             pend;
    logic             found;
    logic [IDX_W-1:0] idx;

    sps_pin_decode u_dec (
        .vmin_mv (pin_vmin_mv),
        .vmax_mv (pin_vmax_mv),
        .crs_mv  (pin_crs_mv),
        .fin_mv  (pin_fin_mv),
        .lim     (pin_lim)
    );

    assign act_lim = host_act ? host_lim : pin_lim;

    sps_offer_pick #(.N_OFFERS(N_OFFERS), .IDX_W(IDX_W)) u_pick (
        .clk    (clk),
        .rst    (rst),
        .offers (tbl),
        .lim    (act_lim),
        .found  (found),
        .idx    (idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_OFFERS; i++) tbl[i] <= '0;
            host_lim <= '0;
            host_act <= 1'b0;
            pend     <= 1'b0;
            pick_idx <= '0;
            op_cur   <= SAFE_CUR;
            safe_pwr <= 1'b1;
        end else begin
            pend <= list_stb | host_wr;
            if (list_stb) begin
                for (int i = 0; i < N_OFFERS; i++) begin
                    tbl[i].valid <= list_valid[i];
                    tbl[i].volt  <= list_volt[i*VOLT_W +: VOLT_W];
                    tbl[i].imax  <= list_imax[i*CUR_W +: CUR_W];
                end
            end
            if (host_wr) begin
                host_act      <= 1'b1;
                host_lim.vmin <= host_vmin;
                host_lim.vmax <= host_vmax;
                host_lim.isnk <= host_isnk;
            end
            if (pend) begin
                safe_pwr <= !found;
                pick_idx <= found ? idx : '0;
                op_cur   <= found ? act_lim.isnk : SAFE_CUR;
            end
        end
    end

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !pend |=> $stable({pick_idx, op_cur, safe_pwr}));

    assert_reset_safe_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (safe_pwr && op_cur == SAFE_CUR && pick_idx == '0));

    assert_host_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        host_act |=> host_act);

    assert_host_origin_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(host_act) |-> $past(host_wr));

endmodule

// File: tb/tb_sink_offer_select.sv
module tb_sink_offer_select;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] pin_vmin_mv = '0, pin_vmax_mv = '0, pin_crs_mv = '0, pin_fin_mv = '0;
    logic        list_stb = 1'b0;
    logic [6:0]  list_valid = '0;
    logic [69:0] list_volt = '0;
    logic [69:0] list_imax = '0;
    logic        host_wr = 1'b0;
    logic [9:0]  host_vmin = '0, host_vmax = '0, host_isnk = '0;
    logic [2:0]  pick_idx;
    logic [9:0]  op_cur;
    logic        safe_pwr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    sink_offer_select dut (
        .clk(clk), .rst(rst),
        .pin_vmin_mv(pin_vmin_mv), .pin_vmax_mv(pin_vmax_mv),
        .pin_crs_mv(pin_crs_mv), .pin_fin_mv(pin_fin_mv),
        .list_stb(list_stb), .list_valid(list_valid),
        .list_volt(list_volt), .list_imax(list_imax),
        .host_wr(host_wr), .host_vmin(host_vmin), .host_vmax(host_vmax),
        .host_isnk(host_isnk),
        .pick_idx(pick_idx), .op_cur(op_cur), .safe_pwr(safe_pwr)
    );

    typedef struct packed {
        logic [11:0] vmn;
        logic [11:0] vmx;
        logic [11:0] crs;
        logic [11:0] fin;
        logic [2:0]  idx;
        logic [9:0]  cur;
        logic        safe;
    } vec_t;

    // offers: 0:5V/3A 1:9V/3A 2:15V/3A 3:20V/2.25A 4:9V/5A
    localparam vec_t VECS [12] = '{
        '{12'd1000, 12'd1500, 12'd500,  12'd0,    3'd2, 10'd100, 1'b0}, // R1 window 9-15
        '{12'd100,  12'd3000, 12'd1000, 12'd300,  3'd3, 10'd225, 1'b0}, // R5 equal current ok
        '{12'd100,  12'd3000, 12'd1000, 12'd900,  3'd2, 10'd250, 1'b0}, // R5 20V too weak
        '{12'd1000, 12'd1000, 12'd2000, 12'd0,    3'd4, 10'd400, 1'b0}, // R5 only 5A entry
        '{12'd1000, 12'd1000, 12'd1000, 12'd1500, 3'd1, 10'd275, 1'b0}, // tie lowest index
        '{12'd2500, 12'd3000, 12'd248,  12'd249,  3'd3, 10'd25,  1'b0}, // R3 R4 edge 249
        '{12'd1348, 12'd1347, 12'd0,    12'd0,    3'd0, 10'd90,  1'b1}, // R2 empty window
        '{12'd0,    12'd4000, 12'd2779, 12'd1921, 3'd0, 10'd90,  1'b1}, // top bands, none
        '{12'd0,    12'd4000, 12'd2778, 12'd1920, 3'd4, 10'd475, 1'b0}, // R3 R4 upper edges
        '{12'd786,  12'd787,  12'd786,  12'd787,  3'd1, 10'd150, 1'b0}, // R7 edge 787
        '{12'd0,    12'd1920, 12'd1347, 12'd1348, 3'd2, 10'd275, 1'b0}, // R7 edge 1920
        '{12'd100,  12'd3000, 12'd1348, 12'd786,  3'd4, 10'd325, 1'b0}  // R5 sum 325
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_out(input string tag, input int e_idx, input int e_cur, input int e_safe);
        chk({tag, " idx"}, int'(pick_idx), e_idx);
        chk({tag, " cur"}, int'(op_cur), e_cur);
        chk({tag, " safe"}, int'(safe_pwr), e_safe);
    endtask

    task automatic load_offers(input logic [6:0] vmask);
        int v [7] = '{100, 180, 300, 400, 180, 0, 0};
        int c [7] = '{300, 300, 300, 225, 500, 0, 0};
        for (int i = 0; i < 7; i++) begin
            list_volt[i*10 +: 10] = 10'(v[i]);
            list_imax[i*10 +: 10] = 10'(c[i]);
        end
        list_valid = vmask;
    endtask

    task automatic set_pins(input logic [11:0] a, input logic [11:0] b,
                            input logic [11:0] c, input logic [11:0] d);
        pin_vmin_mv = a; pin_vmax_mv = b; pin_crs_mv = c; pin_fin_mv = d;
    endtask

    // strobe at one edge, result visible after the next edge
    task automatic pulse(input bit stb, input bit wr);
        @(negedge clk);
        list_stb = stb; host_wr = wr;
        @(negedge clk);
        list_stb = 1'b0; host_wr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 50000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got 0 expected 1 (run completion)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        load_offers(7'b0011111);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_out("R10 reset state", 0, 90, 1);

        // table walk: R1 R2 R3 R4 R5 R7
        for (int k = 0; k < 12; k++) begin
            set_pins(VECS[k].vmn, VECS[k].vmx, VECS[k].crs, VECS[k].fin);
            pulse(1'b1, 1'b0);
            chk_out($sformatf("vec %0d (R1 R2 R3 R4 R5 R7 R9)", k),
                    int'(VECS[k].idx), int'(VECS[k].cur), int'(VECS[k].safe));
        end

        // R10: pin and list changes without a strobe leave outputs frozen
        set_pins(12'd1000, 12'd1500, 12'd500, 12'd0);
        load_offers(7'b0000001);
        repeat (3) @(negedge clk);
        chk_out("R10 hold", 4, 325, 0);

        // R6: cleared valid bit removes the 15 V entry
        load_offers(7'b0011011);
        pulse(1'b1, 1'b0);
        chk_out("R6 invalid skipped", 1, 100, 0);

        // R9: empty pin window gives safe power
        load_offers(7'b0011111);
        set_pins(12'd1348, 12'd1347, 12'd0, 12'd0);
        pulse(1'b1, 1'b0);
        chk_out("R9 fallback", 0, 90, 1);

        // R8: host limits 5-20 V, 1 A replace the empty pin window
        host_vmin = 10'd100; host_vmax = 10'd400; host_isnk = 10'd100;
        pulse(1'b0, 1'b1);
        chk_out("R8 host write", 3, 100, 0);
        pulse(1'b1, 1'b0);
        chk_out("R8 host persists", 3, 100, 0);

        // same cycle: new list (20 V gone) and new host window 9-15 V, 3 A
        load_offers(7'b0010111);
        host_vmin = 10'd180; host_vmax = 10'd300; host_isnk = 10'd300;
        pulse(1'b1, 1'b1);
        chk_out("R8 list+host same cycle", 2, 300, 0);

        // R8 R10: reset drops host limits
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk_out("R10 reset again", 0, 90, 1);
        load_offers(7'b0011111);
        set_pins(12'd1000, 12'd1500, 12'd500, 12'd0);
        pulse(1'b1, 1'b0);
        chk_out("R8 pins after reset", 2, 100, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule